// File: doc/BRIEF.md
# Per-bin fractional delay rotator

The rotator takes the positive-frequency half of each FFT output frame and turns every bin by a phase that grows linearly with the bin number. This removes a residual delay smaller than one sample from the spectrum before cross-multiplication. The delay is not constant. At the start of a model period an offset and a per-frame slope are loaded. Every completed frame then moves the delay on by the slope. After a set number of frames the sequence starts again from the offset.

Bins arrive as signed 16-bit real/imaginary pairs, with a flag on the first bin of a frame. For each bin the phase is built by accumulating the frame delay once per bin. A CORDIC-style function turns the upper 14 bits of that phase into cosine and sine. A complex multiply with rounding and saturation follows. Each result leaves as a write to one half of an external ping-pong buffer, with an address equal to the bin position. The half in use changes after every completed frame.

Top module: `fdr_rotator`

## Requirements
- R1: After reset `out_valid` is low, the write bank is 0, the delay is 0 and the frame index is 1. A frame sent without any load is therefore passed through with a phase of zero.
- R2: A bin with `in_valid` high and `in_first` low is dropped when no frame is open. No write results from it. A frame is open from its first bin until its last bin, or until a load.
- R3: The k-th bin of a frame (k = 1 for the bin that carries `in_first`) is written at `out_addr` = k−1. A new `in_first` restarts the count at address 0.
- R4: The phase of bin k is the upper 14 bits of (k·τ mod 2^W), where W = TAU_FRAC + log2(NFFT). τ is in units of 2^−TAU_FRAC sample, and the phase is in units of 2^−14 turn.
- R5: With unit amplitude 16384 for cosine C and sine S, the outputs are `out_re` = round((re·C − im·S)/16384) and `out_im` = round((im·C + re·S)/16384). Each is within 6 LSB of the ideal value.
- R6: Results beyond the 16-bit range are clamped to 32767 or −32768.
- R7: A bin accepted at clock edge E produces its write in the cycle after edge E+2. This is three register stages, and valid is delayed the same amount as data.
- R8: Frame f of a model period uses τ = d + e·(f−1). τ advances only when the (NFFT/2)-th bin of a frame is accepted. An abandoned frame leaves τ unchanged.
- R9: After the frame numbered FRAMES completes, the frame index returns to 1 and τ returns to d.
- R10: `out_bank` is 0 for the first frame after reset and toggles after every completed frame. All writes of one frame carry the same bank.
- R11: A `mdl_load` pulse stores d and e, sets τ = d and the frame index to 1, and closes any open frame. A bin presented in the same cycle as the load is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mdl_load | input | 1 | Load the delay model and start a model period |
| mdl_d | input | TAU_FRAC+log2(NFFT) | Delay offset d, two's complement, 2^−TAU_FRAC sample units |
| mdl_e | input | TAU_FRAC+log2(NFFT) | Delay step per frame e, same format |
| in_valid | input | 1 | Input bin present |
| in_first | input | 1 | Bin is the first positive-frequency bin of a frame |
| in_re | input | 16 | Bin real part, signed |
| in_im | input | 16 | Bin imaginary part, signed |
| out_valid | output | 1 | Write strobe to the ping-pong buffer |
| out_bank | output | 1 | Buffer half written |
| out_addr | output | log2(NFFT/2) | Entry address in the buffer half |
| out_re | output | 16 | Rotated real part, signed |
| out_im | output | 16 | Rotated imaginary part, signed |

## Verification
A wrong delay register or a slipped phase accumulator shows up as rotated values that drift from the expected ones. The error grows with bin index, so it appears within the first few writes of the affected frame. A lost or extra frame-completion event shows at the next frame: the bank bit fails to flip, and every bin of that frame carries the wrong delay. At the wrap point, a frame counter that is off by one is visible only in the frame after the wrap, which is why the bench runs a whole model period plus one frame.

// File: rtl/fdr_pkg.sv
package fdr_pkg;
  localparam int DATA_W = 16;
  localparam int PH_W   = 14;
  localparam int TRIG_W = 18;
  localparam int CORD_N = 16;
  localparam int ZW     = 21;   // angle in 2^-20 turn, plus sign
  localparam int XW     = 24;   // CORDIC datapath, 4 guard bits
  localparam int PW     = 36;   // product width

  localparam logic signed [XW-1:0] CORD_X0 = 24'sd159188; // 16384*16/K
  localparam logic signed [XW-1:0] CORD_RND = 24'sd8;

  typedef logic signed [DATA_W-1:0] smp_t;

  typedef struct packed {
    logic signed [TRIG_W-1:0] c;
    logic signed [TRIG_W-1:0] s;
  } trig_t;

  typedef struct packed {
    smp_t re;
    smp_t im;
  } cplx_t;

  // arctan(2^-k) in units of 2^-20 turn
  function automatic logic signed [ZW-1:0] atan_step(input int k);
    case (k)
      0:  return 21'sd131072;
      1:  return 21'sd77376;
      2:  return 21'sd40884;
      3:  return 21'sd20753;
      4:  return 21'sd10417;
      5:  return 21'sd5214;
      6:  return 21'sd2607;
      7:  return 21'sd1304;
      8:  return 21'sd652;
      9:  return 21'sd326;
      10: return 21'sd163;
      11: return 21'sd81;
      12: return 21'sd41;
      13: return 21'sd20;
      14: return 21'sd10;
      default: return 21'sd5;
    endcase
  endfunction

  // Cosine and sine of a 14-bit phase, amplitude 16384
  function automatic trig_t sin_cos(input logic [PH_W-1:0] ph);
    logic signed [XW-1:0] x, y, xn, yn;
    logic signed [ZW-1:0] z;
    logic signed [TRIG_W-1:0] cr, sr;
    trig_t t;
    x = CORD_X0;
    y = '0;
    z = $signed({3'b000, ph[PH_W-3:0], 6'b000000});
    for (int k = 0; k < CORD_N; k++) begin
      if (!z[ZW-1]) begin
        xn = x - (y >>> k);
        yn = y + (x >>> k);
        z  = z - atan_step(k);
      end else begin
        xn = x + (y >>> k);
        yn = y - (x >>> k);
        z  = z + atan_step(k);
      end
      x = xn;
      y = yn;
    end
    cr = TRIG_W'((x + CORD_RND) >>> 4);
    sr = TRIG_W'((y + CORD_RND) >>> 4);
    case (ph[PH_W-1:PH_W-2])
      2'd0: begin t.c = cr;  t.s = sr;  end
      2'd1: begin t.c = -sr; t.s = cr;  end
      2'd2: begin t.c = -cr; t.s = -sr; end
      default: begin t.c = sr; t.s = -cr; end
    endcase
    return t;
  endfunction

  function automatic smp_t sat_round(input logic signed [PW-1:0] acc);
    logic signed [PW-1:0] r;
    r = (acc + 36'sd8192) >>> 14;
    if (r > 36'sd32767)       return 16'sh7fff;
    else if (r < -36'sd32768) return 16'sh8000;
    else                      return smp_t'(r);
  endfunction

  function automatic cplx_t rotate(input smp_t re, input smp_t im, input trig_t t);
    logic signed [PW-1:0] rc, is, ic, rs;
    cplx_t o;
    rc = PW'(re) * PW'(t.c);
    is = PW'(im) * PW'(t.s);
    ic = PW'(im) * PW'(t.c);
    rs = PW'(re) * PW'(t.s);
    o.re = sat_round(rc - is);
    o.im = sat_round(ic + rs);
    return o;
  endfunction
endpackage

// File: rtl/fdr_model_ctrl.sv
module fdr_model_ctrl #(
  parameter int ACC_W  = 24,
  parameter int FRAMES = 160,
  parameter int FCW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ACC_W-1:0] ld_d,
  input  logic [ACC_W-1:0] ld_e,
  input  logic             frame_done,
  output logic [ACC_W-1:0] tau,
  output logic [FCW-1:0]   fcnt,
  output logic             bank
);
  logic [ACC_W-1:0] d_r, e_r;
  logic             last_frame;

  assign last_frame = (fcnt == FCW'(FRAMES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_r  <= '0;
      e_r  <= '0;
      tau  <= '0;
      fcnt <= FCW'(1);
      bank <= 1'b0;
    end else begin
      if (load) begin
        d_r  <= ld_d;
        e_r  <= ld_e;
        tau  <= ld_d;
        fcnt <= FCW'(1);
      end else if (frame_done) begin
        if (last_frame) begin
          tau  <= d_r;
          fcnt <= FCW'(1);
        end else begin
          tau  <= tau + e_r;
          fcnt <= fcnt + FCW'(1);
        end
      end
      if (frame_done) bank <= ~bank;
    end
  end
endmodule

// File: rtl/fdr_bin_seq.sv
module fdr_bin_seq
  import fdr_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int BINS  = 512,
  parameter int AW    = 9,
  localparam int IW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             in_valid,
  input  logic             in_first,
  input  smp_t             in_re,
  input  smp_t             in_im,
  input  logic [ACC_W-1:0] tau,
  input  logic             bank,
  output logic             acc_ev,
  output logic             frame_done,
  output logic             s1_v,
  output logic             s1_bank,
  output logic [AW-1:0]    s1_addr,
  output smp_t             s1_re,
  output smp_t             s1_im,
  output logic [PH_W-1:0]  s1_ph
);
  logic [IW-1:0]    idx, nxt_idx;
  logic [ACC_W-1:0] ph_acc, nxt_ph;
  logic             active;

  always_comb begin
    acc_ev     = in_valid && !load && (in_first || active);
    nxt_idx    = in_first ? IW'(1) : idx + IW'(1);
    nxt_ph     = in_first ? tau : ph_acc + tau;
    frame_done = acc_ev && (nxt_idx == IW'(BINS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      ph_acc  <= '0;
      active  <= 1'b0;
      s1_v    <= 1'b0;
      s1_bank <= 1'b0;
      s1_addr <= '0;
      s1_re   <= '0;
      s1_im   <= '0;
      s1_ph   <= '0;
    end else begin
      s1_v <= acc_ev;
      if (load) begin
        active <= 1'b0;
      end else if (acc_ev) begin
        idx     <= nxt_idx;
        ph_acc  <= nxt_ph;
        active  <= !frame_done;
        s1_bank <= bank;
        s1_addr <= AW'(nxt_idx - IW'(1));
        s1_re   <= in_re;
        s1_im   <= in_im;
        s1_ph   <= nxt_ph[ACC_W-1 -: PH_W];
      end
    end
  end
endmodule

// File: rtl/fdr_rot_pipe.sv
module fdr_rot_pipe
  import fdr_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s1_v,
  input  logic            s1_bank,
  input  logic [AW-1:0]   s1_addr,
  input  smp_t            s1_re,
  input  smp_t            s1_im,
  input  logic [PH_W-1:0] s1_ph,
  output logic            out_v,
  output logic            out_bank,
  output logic [AW-1:0]   out_addr,
  output smp_t            out_re,
  output smp_t            out_im
);
  logic          s2_v, s2_bank;
  logic [AW-1:0] s2_addr;
  smp_t          s2_re, s2_im;
  trig_t         s2_t;
  cplx_t         rot;

  assign rot = rotate(s2_re, s2_im, s2_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v     <= 1'b0;
      s2_bank  <= 1'b0;
      s2_addr  <= '0;
      s2_re    <= '0;
      s2_im    <= '0;
      s2_t     <= '0;
      out_v    <= 1'b0;
      out_bank <= 1'b0;
      out_addr <= '0;
      out_re   <= '0;
      out_im   <= '0;
    end else begin
      s2_v  <= s1_v;
      out_v <= s2_v;
      if (s1_v) begin
        s2_bank <= s1_bank;
        s2_addr <= s1_addr;
        s2_re   <= s1_re;
        s2_im   <= s1_im;
        s2_t    <= sin_cos(s1_ph);
      end
      if (s2_v) begin
        out_bank <= s2_bank;
        out_addr <= s2_addr;
        out_re   <= rot.re;
        out_im   <= rot.im;
      end
    end
  end
endmodule

// File: rtl/fdr_rotator.sv
module fdr_rotator
  import fdr_pkg::*;
#(
  parameter int  NFFT     = 1024,
  parameter int  FRAMES   = 160,
  parameter int  TAU_FRAC = 14,
  localparam int LOG2N    = $clog2(NFFT),
  localparam int ACC_W    = TAU_FRAC + LOG2N,
  localparam int BINS     = NFFT / 2,
  localparam int AW       = $clog2(BINS),
  localparam int FCW      = $clog2(FRAMES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mdl_load,
  input  logic [ACC_W-1:0]   mdl_d,
  input  logic [ACC_W-1:0]   mdl_e,
  input  logic               in_valid,
  input  logic               in_first,
  input  logic signed [15:0] in_re,
  input  logic signed [15:0] in_im,
  output logic               out_valid,
  output logic               out_bank,
  output logic [AW-1:0]      out_addr,
  output logic signed [15:0] out_re,
  output logic signed [15:0] out_im
);
  logic [ACC_W-1:0] tau;
  logic [FCW-1:0]   frm_idx;
  logic             bank, acc_ev, frame_done;
  logic             s1_v, s1_bank;
  logic [AW-1:0]    s1_addr;
  smp_t             s1_re, s1_im;
  logic [PH_W-1:0]  s1_ph;

  fdr_model_ctrl #(.ACC_W(ACC_W), .FRAMES(FRAMES), .FCW(FCW)) u_model (
    .clk(clk), .rst_n(rst_n), .load(mdl_load), .ld_d(mdl_d), .ld_e(mdl_e),
    .frame_done(frame_done), .tau(tau), .fcnt(frm_idx), .bank(bank)
  );

  fdr_bin_seq #(.ACC_W(ACC_W), .BINS(BINS), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(mdl_load), .in_valid(in_valid),
    .in_first(in_first), .in_re(in_re), .in_im(in_im), .tau(tau),
    .bank(bank), .acc_ev(acc_ev), .frame_done(frame_done), .s1_v(s1_v),
    .s1_bank(s1_bank), .s1_addr(s1_addr), .s1_re(s1_re), .s1_im(s1_im),
    .s1_ph(s1_ph)
  );

  fdr_rot_pipe #(.AW(AW)) u_rot (
    .clk(clk), .rst_n(rst_n), .s1_v(s1_v), .s1_bank(s1_bank),
    .s1_addr(s1_addr), .s1_re(s1_re), .s1_im(s1_im), .s1_ph(s1_ph),
    .out_v(out_valid), .out_bank(out_bank), .out_addr(out_addr),
    .out_re(out_re), .out_im(out_im)
  );
endmodule

// File: rtl/fdr_rotator_chk.sv
module fdr_rotator_chk #(
  parameter int AW     = 9,
  parameter int FCW    = 8,
  parameter int FRAMES = 160
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mdl_load,
  input logic           acc_ev,
  input logic           in_first,
  input logic           out_valid,
  input logic           out_bank,
  input logic [AW-1:0]  out_addr,
  input logic [FCW-1:0] frm_idx
);
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ev |-> ##3 out_valid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(acc_ev, 3));

  p_first_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ev && in_first) |-> ##3 (out_addr == '0));

  p_load_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mdl_load |-> ##3 !out_valid);

  p_bank_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid) && out_addr != '0) |-> (out_bank == $past(out_bank)));

  p_frame_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_idx >= FCW'(1)) && (frm_idx <= FCW'(FRAMES)));
endmodule

bind fdr_rotator fdr_rotator_chk #(.AW(AW), .FCW(FCW), .FRAMES(FRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdl_load(mdl_load), .acc_ev(acc_ev),
  .in_first(in_first), .out_valid(out_valid), .out_bank(out_bank),
  .out_addr(out_addr), .frm_idx(frm_idx)
);

// File: tb/sim_fdr_rotator.sv
`timescale 1ns/1ps
module sim_fdr_rotator;
  localparam int  NF   = 32;
  localparam int  FR   = 3;
  localparam int  TF   = 14;
  localparam int  ACC  = TF + 5;
  localparam int  BINS = NF / 2;
  localparam int  AW   = 4;
  localparam int  TOL  = 6;
  localparam longint MASK = (64'sd1 <<< ACC) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdl_load = 1'b0;
  logic [ACC-1:0] mdl_d = '0, mdl_e = '0;
  logic in_valid = 1'b0, in_first = 1'b0;
  logic signed [15:0] in_re = '0, in_im = '0;
  logic out_valid, out_bank;
  logic [AW-1:0] out_addr;
  logic signed [15:0] out_re, out_im;

  int cyc = 0;
  int total = 0, bad = 0;

  int exp_re[0:1023], exp_im[0:1023], exp_addr[0:1023], exp_bank[0:1023], exp_edge[0:1023];
  int got_re[0:1023], got_im[0:1023], got_addr[0:1023], got_bank[0:1023], got_edge[0:1023];
  int exp_n = 0, got_n = 0, exp_base = 0, got_base = 0;

  longint b_tau = 0, b_d = 0, b_e = 0;
  int b_f = 1, b_k = 0;
  bit b_bank = 0, b_active = 0;
  logic [31:0] lcg = 32'h1234_5678;

  fdr_rotator #(.NFFT(NF), .FRAMES(FR), .TAU_FRAC(TF)) u0 (
    .clk(clk), .rst_n(rst_n), .mdl_load(mdl_load), .mdl_d(mdl_d), .mdl_e(mdl_e),
    .in_valid(in_valid), .in_first(in_first), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_bank(out_bank), .out_addr(out_addr),
    .out_re(out_re), .out_im(out_im)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid && got_n < 1024) begin
      got_re[got_n]   = int'(out_re);
      got_im[got_n]   = int'(out_im);
      got_addr[got_n] = int'(out_addr);
      got_bank[got_n] = int'(out_bank);
      got_edge[got_n] = cyc;
      got_n++;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int expv, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  function automatic int ideal(input int re, input int im, input int ph, input bit want_im);
    real a, c, s, v;
    int r;
    a = 2.0 * 3.14159265358979 * ph / 16384.0;
    c = $cos(a);
    s = $sin(a);
    v = want_im ? (im * c + re * s) : (re * c - im * s);
    r = int'($floor(v + 0.5));
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  function automatic int bin_phase(input longint tau, input int k);
    longint p;
    p = (tau * k) & MASK;
    return int'(p >> (ACC - 14));
  endfunction

  task automatic model_advance();
    b_bank = ~b_bank;
    if (b_f == FR) begin b_tau = b_d; b_f = 1; end
    else begin b_tau = (b_tau + b_e) & MASK; b_f++; end
  endtask

  task automatic push_exp(input int re, input int im);
    int ph;
    ph = bin_phase(b_tau, b_k);
    exp_re[exp_n]   = ideal(re, im, ph, 1'b0);
    exp_im[exp_n]   = ideal(re, im, ph, 1'b1);
    exp_addr[exp_n] = b_k - 1;
    exp_bank[exp_n] = int'(b_bank);
    exp_edge[exp_n] = cyc + 1;
    exp_n++;
  endtask

  task automatic send(input bit first, input int re, input int im);
    bit taken;
    @(negedge clk);
    in_valid = 1'b1;
    in_first = first;
    in_re = 16'(re);
    in_im = 16'(im);
    taken = first || b_active;
    if (first) b_k = 1;
    else if (b_active) b_k++;
    if (taken) begin
      push_exp(re, im);
      if (b_k == BINS) begin b_active = 0; model_advance(); end
      else b_active = 1;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_first = 1'b0;
    end
  endtask

  task automatic load(input longint d, input longint e, input bit with_bin);
    @(negedge clk);
    mdl_load = 1'b1;
    mdl_d = ACC'(d);
    mdl_e = ACC'(e);
    in_valid = with_bin;
    in_first = with_bin;
    in_re = 16'sd9000;
    in_im = 16'sd100;
    b_d = d & MASK; b_e = e & MASK; b_tau = b_d; b_f = 1; b_active = 0;
    @(negedge clk);
    mdl_load = 1'b0;
    in_valid = 1'b0;
    in_first = 1'b0;
  endtask

  task automatic get_pat(input int mode, input int k, output int re, output int im);
    case (mode)
      0: begin re = 12000; im = -5000; end
      1: begin re = k * 1500 - 9000; im = 7000 - k * 700; end
      2: begin
        lcg = lcg * 32'd1103515245 + 32'd12345;
        re = int'($signed(lcg[23:8]));
        lcg = lcg * 32'd1103515245 + 32'd12345;
        im = int'($signed(lcg[23:8]));
      end
      default: begin re = 32767; im = -32768; end
    endcase
  endtask

  task automatic run_frame(input int mode, input bit gaps);
    int re, im;
    for (int k = 1; k <= BINS; k++) begin
      get_pat(mode, k, re, im);
      send(k == 1, re, im);
      if (gaps && (k % 4 == 0)) idle(1);
    end
    idle(1);
  endtask

  task automatic compare(input string rq);
    int n;
    idle(6);
    chk((got_n - got_base) == (exp_n - exp_base), "R2", got_n - got_base, exp_n - exp_base, "write count");
    n = exp_n - exp_base;
    if ((got_n - got_base) < n) n = got_n - got_base;
    for (int i = 0; i < n; i++) begin
      int g, x;
      g = got_base + i;
      x = exp_base + i;
      chk(got_addr[g] == exp_addr[x], "R3", got_addr[g], exp_addr[x], "address");
      chk(got_bank[g] == exp_bank[x], "R10", got_bank[g], exp_bank[x], "bank");
      chk(got_edge[g] == exp_edge[x] + 2, "R7", got_edge[g], exp_edge[x] + 2, "latency");
      chk((got_re[g] - exp_re[x] <= TOL) && (exp_re[x] - got_re[g] <= TOL), rq, got_re[g], exp_re[x], "real");
      chk((got_im[g] - exp_im[x] <= TOL) && (exp_im[x] - got_im[g] <= TOL), rq, got_im[g], exp_im[x], "imag");
    end
    got_base = got_n;
    exp_base = exp_n;
  endtask

  // R1: reset state, zero delay passthrough, bank 0
  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0, "valid in reset");
    rst_n = 1'b1;
    idle(2);
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0, "valid after reset");
    run_frame(1, 1'b0);
    compare("R1");
  endtask

  // R2: bins without an open frame are dropped
  task automatic t_stray();
    send(1'b0, 1000, 2000);
    send(1'b0, 3000, 4000);
    send(1'b0, -500, 600);
    compare("R2");
  endtask

  // R4 R5 R8: loaded model, two frames with different data and gaps
  task automatic t_model();
    load(3000, -1100, 1'b0);
    run_frame(1, 1'b1);
    run_frame(2, 1'b0);
    compare("R4");
    run_frame(0, 1'b1);
    compare("R5");
  endtask

  // R3 R8: abandoned partial frame, restart, delay not advanced
  task automatic t_restart();
    int re, im;
    for (int k = 1; k <= 5; k++) begin
      get_pat(2, k, re, im);
      send(k == 1, re, im);
    end
    run_frame(2, 1'b0);
    compare("R8");
  endtask

  // R9: full model period plus one frame
  task automatic t_period();
    load(-7000, 2345, 1'b0);
    for (int f = 0; f <= FR; f++) run_frame(2, 1'b1);
    compare("R9");
  endtask

  // R6: 45 degree step with full-scale data saturates
  task automatic t_sat();
    load(longint'(1) <<< (ACC - 3), 0, 1'b0);
    run_frame(3, 1'b0);
    compare("R6");
  endtask

  // R11: bin in the load cycle is discarded, new delay used afterwards
  task automatic t_load_drop();
    int re, im;
    for (int k = 1; k <= 3; k++) begin
      get_pat(0, k, re, im);
      send(k == 1, re, im);
    end
    load(500, 200, 1'b1);
    send(1'b0, 4000, 4000);
    run_frame(1, 1'b0);
    compare("R11");
  endtask

  initial begin
    t_reset();
    t_stray();
    t_model();
    t_restart();
    t_period();
    t_sat();
    t_load_drop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule